// File: doc/BRIEF.md
# Shared Interrupt Source Router

This block sits between a bank of external level-sensitive interrupt lines and the interrupt inputs of several processors. Every source keeps four pieces of state: a pending level, an enable bit, a target CPU pin number and a target processor. For each processor and each pin, the block raises the output when at least one source is enabled, pending and mapped to that processor and pin. A separate local request per processor and pin is ORed into the same output.

Software controls the router through a simple 32-bit register port with a valid, a write flag, a byte address and write data. Packed pending and enable words can be read back. Enables are changed through separate set and clear windows. A wedge register lets software force a source's pending level. Each source has a pin-map word and a processor-map word. The processor map is written as a one-hot vector. The router stores it as an index and returns it as a one-hot vector on read. All routing is combinational from the stored state. A change of enable, level or mapping therefore moves the output on the next clock edge: the old pin drops and the new pin rises in the same cycle.

Top module: `shared_irq_router`

## Requirements
- R1: After reset, every source is disabled and not pending. Every pin-map word reads 0x8000_0000 (flag set, pin 0). Every processor-map word reads 0. `cpu_irq` then equals only the local requests, and `bus_rdata` is 0.
- R2: A source's pending level is updated at the first clock edge where its `src_in` line differs from its value at the previous edge, and it then equals the line. The level is tracked whether or not the source is enabled. The packed pending word at 0x0000+4w holds source 32w+b in bit b.
- R3: The output bit `cpu_irq[v*(NUM_PIN+PIN_OFS)+PIN_OFS+p]` is the OR of `local_req[v*NUM_PIN+p]` and every source that is enabled, pending, mapped to processor v and mapped to pin p. The lowest PIN_OFS bits of each processor's group are always 0.
- R4: A write to the set-enable window (0x0300+4w) enables source 32w+b for each 1 in bit b. A write to the clear-enable window (0x0200+4w) disables those sources. Zero bits change nothing. The enable word at 0x0100+4w reads back the enables.
- R5: A window word index w is accepted only when 32(w+1) <= NUM_SRC. For any other w, the pending and enable reads return 0 and the set and clear writes change nothing.
- R6: A write to the wedge register 0x0400 sets the pending level of the source numbered in bits 30:0 to the value of bit 31. This takes precedence over a line change in the same cycle. A source number >= NUM_SRC is ignored.
- R7: The pin-map word of source s is at 0x1000+4s and holds the flag in bit 31 and the pin number in bits 7:0. A write whose pin number is >= NUM_PIN leaves the word unchanged. A read returns {flag, 23'b0, pin}.
- R8: The processor-map word of source s is at 0x2000+32s. A write stores the index of the lowest set bit, or "unmapped" for zero. A write whose lowest set bit is >= NUM_VP is ignored. A read returns the one-hot vector, or 0 when the source is unmapped.
- R9: When a pending, enabled source is remapped, its old pin falls and its new pin rises after the same clock edge. No stale level is left on the old pin.
- R10: Reads return data registered at the accepting edge, and the data holds until the next read. Unaligned or unmapped addresses (for example 0x0800) read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_SRC | External interrupt levels |
| local_req | input | NUM_VP*NUM_PIN | Per-processor, per-pin local requests ORed into outputs |
| bus_valid | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cpu_irq | output | NUM_VP*(NUM_PIN+PIN_OFS) | Processor interrupt pins, grouped per processor |

## Verification
The assertions check the following on every cycle:
- a local request always reaches its pin;
- the offset pins stay low;
- an idle enable state with no local requests gives silent outputs;
- set and clear writes land on the addressed enable bits;
- a line change is captured as the pending level;
- processor-map reads are one-hot or zero;
- unmapped reads return 0.

Only the bench scenarios can show the full OR routing across many sources against an independent model. The same applies to the clearing of a stale pin on remap, the rejection of illegal pin and processor map writes, the precedence of the wedge, and the range check on window words.

// File: rtl/shared_irq_router.sv
module shared_irq_router #(
  parameter int NUM_SRC = 64,
  parameter int NUM_VP  = 4,
  parameter int NUM_PIN = 6,
  parameter int PIN_OFS = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_SRC-1:0]                src_in,
  input  logic [NUM_VP*NUM_PIN-1:0]         local_req,
  input  logic                              bus_valid,
  input  logic                              bus_we,
  input  logic [15:0]                       bus_addr,
  input  logic [31:0]                       bus_wdata,
  output logic [31:0]                       bus_rdata,
  output logic [NUM_VP*(NUM_PIN+PIN_OFS)-1:0] cpu_irq
);
  localparam int CPU_PINS = NUM_PIN + PIN_OFS;
  localparam int NWORDS   = NUM_SRC / 32;
  localparam int VP_W     = (NUM_VP  > 1) ? $clog2(NUM_VP)  : 1;
  localparam int PIN_W    = (NUM_PIN > 1) ? $clog2(NUM_PIN) : 1;

  logic [NUM_SRC-1:0] src_q, pend, en, flag, vp_ok;
  logic [PIN_W-1:0]   pin_r [NUM_SRC];
  logic [VP_W-1:0]    vp_r  [NUM_SRC];

  wire        wr      = bus_valid & bus_we;
  wire        rd      = bus_valid & ~bus_we;
  wire        aligned = (bus_addr[1:0] == 2'b00);
  wire [5:0]  widx    = bus_addr[7:2];
  wire        win_ok  = aligned && ({26'd0, widx} < 32'(NWORDS));
  wire        sel_pend = (bus_addr[15:8] == 8'h00) && win_ok;
  wire        sel_en   = (bus_addr[15:8] == 8'h01) && win_ok;
  wire        sel_clr  = (bus_addr[15:8] == 8'h02) && win_ok;
  wire        sel_set  = (bus_addr[15:8] == 8'h03) && win_ok;
  wire [30:0] wsrc     = bus_wdata[30:0];
  wire        wedge_ok = (bus_addr == 16'h0400) && ({1'b0, wsrc} < 32'(NUM_SRC));
  wire [9:0]  pidx     = bus_addr[11:2];
  wire        sel_pmap = (bus_addr[15:12] == 4'h1) && aligned && ({22'd0, pidx} < 32'(NUM_SRC));
  wire [7:0]  vidx     = bus_addr[12:5];
  wire        sel_vmap = (bus_addr[15:13] == 3'b001) && aligned && ({24'd0, vidx} < 32'(NUM_SRC));
  wire        pin_legal = ({24'd0, bus_wdata[7:0]} < 32'(NUM_PIN));

  logic       low_found;
  logic [4:0] low_idx;
  always_comb begin
    low_found = 1'b0;
    low_idx   = '0;
    for (int b = 31; b >= 0; b--)
      if (bus_wdata[b]) begin
        low_found = 1'b1;
        low_idx   = 5'(b);
      end
  end
  wire vp_legal = !low_found || ({27'd0, low_idx} < 32'(NUM_VP));

  logic [NUM_SRC-1:0] set_m, clr_m, wedge_hit, pmap_hit, vmap_hit;
  always_comb
    for (int i = 0; i < NUM_SRC; i++) begin
      set_m[i]     = wr && sel_set && (widx == 6'(i / 32)) && bus_wdata[i % 32];
      clr_m[i]     = wr && sel_clr && (widx == 6'(i / 32)) && bus_wdata[i % 32];
      wedge_hit[i] = wr && wedge_ok && (wsrc == 31'(i));
      pmap_hit[i]  = wr && sel_pmap && pin_legal && (pidx == 10'(i));
      vmap_hit[i]  = wr && sel_vmap && vp_legal && (vidx == 8'(i));
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      src_q <= '0;
      pend  <= '0;
      en    <= '0;
      flag  <= '1;
      vp_ok <= '0;
      for (int i = 0; i < NUM_SRC; i++) begin
        pin_r[i] <= '0;
        vp_r[i]  <= '0;
      end
    end else begin
      src_q <= src_in;
      en    <= (en & ~clr_m) | set_m;
      for (int i = 0; i < NUM_SRC; i++) begin
        if (wedge_hit[i])              pend[i] <= bus_wdata[31];
        else if (src_in[i] != src_q[i]) pend[i] <= src_in[i];
        if (pmap_hit[i]) begin
          pin_r[i] <= PIN_W'(bus_wdata[7:0]);
          flag[i]  <= bus_wdata[31];
        end
        if (vmap_hit[i]) begin
          vp_ok[i] <= low_found;
          vp_r[i]  <= VP_W'(low_idx);
        end
      end
    end

  logic [31:0] pw, ew, pv, vv, rd_val;
  always_comb begin
    pw = '0; ew = '0; pv = '0; vv = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (widx == 6'(i / 32)) begin
        pw[i % 32] = pend[i];
        ew[i % 32] = en[i];
      end
      if (pidx == 10'(i)) pv = {flag[i], 23'd0, 8'(pin_r[i])};
      if (vidx == 8'(i) && vp_ok[i]) vv = 32'd1 << vp_r[i];
    end
    rd_val = sel_pend ? pw : sel_en ? ew : sel_pmap ? pv : sel_vmap ? vv : 32'd0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)  bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_val;

  logic route_acc;
  always_comb begin
    cpu_irq = '0;
    for (int v = 0; v < NUM_VP; v++)
      for (int p = 0; p < NUM_PIN; p++) begin
        route_acc = local_req[v*NUM_PIN + p];
        for (int i = 0; i < NUM_SRC; i++)
          if (en[i] && pend[i] && vp_ok[i] && vp_r[i] == VP_W'(v) && pin_r[i] == PIN_W'(p))
            route_acc = 1'b1;
        cpu_irq[v*CPU_PINS + PIN_OFS + p] = route_acc;
      end
  end
endmodule

// File: rtl/shared_irq_router_sva.sv
module shared_irq_router_sva #(
  parameter int NUM_SRC = 64,
  parameter int NUM_VP  = 4,
  parameter int NUM_PIN = 6,
  parameter int PIN_OFS = 2
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic [NUM_SRC-1:0]                  src_in,
  input logic [NUM_VP*NUM_PIN-1:0]           local_req,
  input logic                                bus_valid,
  input logic                                bus_we,
  input logic [15:0]                         bus_addr,
  input logic [31:0]                         bus_wdata,
  input logic [31:0]                         bus_rdata,
  input logic [NUM_VP*(NUM_PIN+PIN_OFS)-1:0] cpu_irq,
  input logic [NUM_SRC-1:0]                  pend,
  input logic [NUM_SRC-1:0]                  en
);
  localparam int CPU_PINS = NUM_PIN + PIN_OFS;
  localparam int NWORDS   = NUM_SRC / 32;

  initial a_r5_src_count: assert (NUM_SRC > 0 && NUM_SRC % 8 == 0 && NUM_SRC <= 256 && NUM_VP <= 32);

  a_r3_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0 && local_req == '0) |-> cpu_irq == '0);

  a_r8_vp_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_we && bus_addr[15:13] == 3'b001) |=> $onehot0(bus_rdata));

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_we && bus_addr == 16'h0800) |=> bus_rdata == 32'd0);

  for (genvar K = 0; K < NUM_VP*NUM_PIN; K++) begin : g_loc
    a_r3_local_reaches_pin: assert property (@(posedge clk) disable iff (!rst_n)
      local_req[K] |-> cpu_irq[(K / NUM_PIN)*CPU_PINS + PIN_OFS + (K % NUM_PIN)]);
  end

  if (PIN_OFS > 0) begin : g_ofs
    for (genvar V = 0; V < NUM_VP; V++) begin : g_vp
      a_r3_offset_low: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq[V*CPU_PINS +: PIN_OFS] == '0);
    end
  end

  for (genvar I = 0; I < NUM_SRC; I++) begin : g_src
    a_r2_track_line: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(src_in[I]) != $past(src_in[I], 2) &&
       !$past(bus_valid && bus_we && bus_addr == 16'h0400)) |-> pend[I] == $past(src_in[I]));
    if (I < NWORDS*32) begin : g_win
      localparam logic [15:0] SET_A = 16'(16'h0300 + 4*(I/32));
      localparam logic [15:0] CLR_A = 16'(16'h0200 + 4*(I/32));
      a_r4_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_we && bus_addr == SET_A && bus_wdata[I % 32]) |=> en[I]);
      a_r4_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_we && bus_addr == CLR_A && bus_wdata[I % 32]) |=> !en[I]);
    end
  end
endmodule

bind shared_irq_router shared_irq_router_sva #(
  .NUM_SRC(NUM_SRC), .NUM_VP(NUM_VP), .NUM_PIN(NUM_PIN), .PIN_OFS(PIN_OFS)
) u_sva (
  .clk(clk), .rst_n(rst_n), .src_in(src_in), .local_req(local_req),
  .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_irq(cpu_irq),
  .pend(pend), .en(en)
);

// File: tb/test_shared_irq_router.sv
module test_shared_irq_router;
  localparam int NS = 64, NV = 4, NP = 6, PO = 2, CP = NP + PO;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NS-1:0] src_in = '0;
  logic [NV*NP-1:0] local_req = '0;
  logic bus_valid = 1'b0, bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NV*CP-1:0] cpu_irq;

  always #2 clk = ~clk;

  shared_irq_router i_shared_irq_router (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .local_req(local_req),
    .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_irq(cpu_irq));

  int n_tests = 0, n_fail = 0;
  bit en_m[NS], pend_m[NS], flag_m[NS], vok_m[NS];
  int pin_m[NS], vp_m[NS];
  logic [NS-1:0] src_m = '0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [NV*CP-1:0] exp_irq();
    logic [NV*CP-1:0] o = '0;
    for (int v = 0; v < NV; v++)
      for (int p = 0; p < NP; p++) begin
        bit b = local_req[v*NP + p];
        for (int i = 0; i < NS; i++)
          if (en_m[i] && pend_m[i] && vok_m[i] && vp_m[i] == v && pin_m[i] == p) b = 1;
        o[v*CP + PO + p] = b;
      end
    return o;
  endfunction

  function automatic logic [31:0] exp_read(logic [15:0] a);
    logic [31:0] r = '0;
    int w = a[7:2];
    if (a[1:0] != 0) return 0;
    if ((a[15:8] == 0 || a[15:8] == 1) && w < NS/32)
      for (int b = 0; b < 32; b++) r[b] = (a[15:8] == 0) ? pend_m[w*32+b] : en_m[w*32+b];
    if (a[15:12] == 1 && a[11:2] < NS) r = {flag_m[a[11:2]], 23'd0, 8'(pin_m[a[11:2]])};
    if (a[15:13] == 1 && a[12:5] < NS && vok_m[a[12:5]]) r = 32'd1 << vp_m[a[12:5]];
    return r;
  endfunction

  function automatic void model_write(logic [15:0] a, logic [31:0] d);
    int w = a[7:2];
    if (a == 16'h0400 && d[30:0] < NS) pend_m[d[30:0]] = d[31];
    if (a[1:0] != 0) return;
    if ((a[15:8] == 2 || a[15:8] == 3) && w < NS/32)
      for (int b = 0; b < 32; b++) if (d[b]) en_m[w*32+b] = (a[15:8] == 3);
    if (a[15:12] == 1 && a[11:2] < NS && d[7:0] < NP) begin
      pin_m[a[11:2]] = d[7:0];
      flag_m[a[11:2]] = d[31];
    end
    if (a[15:13] == 1 && a[12:5] < NS) begin
      if (d == 0) vok_m[a[12:5]] = 0;
      else begin
        int lo = 0;
        while (!d[lo]) lo++;
        if (lo < NV) begin vok_m[a[12:5]] = 1; vp_m[a[12:5]] = lo; end
      end
    end
  endfunction

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_valid = 0; bus_we = 0;
    model_write(a, d);
  endtask

  task automatic rd(logic [15:0] a, string req);
    logic [31:0] e;
    @(negedge clk);
    bus_valid = 1; bus_we = 0; bus_addr = a;
    e = exp_read(a);
    @(posedge clk); #1;
    bus_valid = 0;
    check(req, bus_rdata, e);
  endtask

  task automatic drive_src(logic [NS-1:0] v);
    @(negedge clk);
    src_in = v;
    @(posedge clk); #1;
    for (int i = 0; i < NS; i++) if (v[i] != src_m[i]) pend_m[i] = v[i];
    src_m = v;
  endtask

  task automatic chk_irq(string req);
    check(req, 32'(cpu_irq), 32'(exp_irq()));
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < NS; i++) begin
      en_m[i] = 0; pend_m[i] = 0; flag_m[i] = 1; vok_m[i] = 0; pin_m[i] = 0; vp_m[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(posedge clk); #1;
    // R1 reset state
    check("R1 irq", 32'(cpu_irq), 32'd0);
    check("R1 rdata", bus_rdata, 32'd0);
    rd(16'h0000, "R1 pend");
    rd(16'h0100, "R1 en");
    check("R1 pinmap", exp_read(16'h1014), 32'h8000_0000);
    rd(16'h1014, "R1 pinmap");
    rd(16'h20A0, "R1 vpmap");
    // R2/R3 source 3 -> vp1 pin2
    wr(16'h1000 + 4*3, 32'h8000_0002);
    wr(16'h2000 + 32*3, 32'h0000_0006);
    drive_src(64'h8);
    rd(16'h0000, "R2 pend follows line");
    check("R3 disabled source silent", 32'(cpu_irq), 32'd0);
    wr(16'h0300, 32'h8);
    check("R3 routed bit", 32'(cpu_irq[1*CP + PO + 2]), 32'd1);
    chk_irq("R3");
    wr(16'h0200, 32'h0);
    rd(16'h0100, "R4 zero bits keep enables");
    chk_irq("R4");
    wr(16'h0200, 32'h8);
    check("R4 cleared", 32'(cpu_irq), 32'd0);
    wr(16'h0300, 32'h8);
    drive_src(64'h0);
    check("R2 line low drops pin", 32'(cpu_irq), 32'd0);
    // R6 wedge
    wr(16'h0400, 32'h8000_0003);
    check("R6 wedge raises", 32'(cpu_irq[1*CP + PO + 2]), 32'd1);
    wr(16'h0400, 32'h8000_0040);
    rd(16'h0000, "R6 out of range ignored");
    rd(16'h0004, "R6 out of range ignored");
    wr(16'h0400, 32'h0000_0003);
    chk_irq("R6 wedge clears");
    // R5 window range
    wr(16'h0308, 32'hFFFF_FFFF);
    rd(16'h0100, "R5 bad window write");
    rd(16'h0104, "R5 bad window write");
    rd(16'h0108, "R5 bad window read");
    wr(16'h0304, 32'h0000_0001);
    rd(16'h0104, "R4 upper word");
    // R7 pin map
    wr(16'h1000 + 4*3, 32'h0000_0006);
    rd(16'h100C, "R7 illegal pin kept");
    wr(16'h1000 + 4*3, 32'h0000_0005);
    check("R7 flag cleared", exp_read(16'h100C), 32'h5);
    rd(16'h100C, "R7 readback");
    // R8 vp map
    wr(16'h2000 + 32*3, 32'h0000_000C);
    rd(16'h2060, "R8 lowest bit");
    wr(16'h2000 + 32*3, 32'h0000_0010);
    rd(16'h2060, "R8 out of range kept");
    // R9 remap
    wr(16'h0400, 32'h8000_0003);
    check("R9 before remap", 32'(cpu_irq[2*CP + PO + 5]), 32'd1);
    wr(16'h1000 + 4*3, 32'h8000_0001);
    check("R9 old pin low", 32'(cpu_irq[2*CP + PO + 5]), 32'd0);
    check("R9 new pin high", 32'(cpu_irq[2*CP + PO + 1]), 32'd1);
    wr(16'h2000 + 32*3, 32'h0);
    rd(16'h2060, "R8 unmapped reads 0");
    chk_irq("R9 unmapped drops");
    // R10 unmapped space
    wr(16'h0800, 32'hFFFF_FFFF);
    rd(16'h0800, "R10 unmapped");
    rd(16'h1002, "R10 unaligned");
    @(posedge clk); #1;
    check("R10 rdata holds", bus_rdata, 32'd0);
    chk_irq("R10");
    // random mix
    for (int n = 0; n < 600; n++) begin
      int op = $urandom % 8;
      case (op)
        0: drive_src({$urandom, $urandom});
        1: wr(16'(16'h0300 + 4*($urandom % 3)), $urandom);
        2: wr(16'(16'h0200 + 4*($urandom % 3)), $urandom);
        3: wr(16'h0400, {1'($urandom), 31'($urandom % 72)});
        4: wr(16'(16'h1000 + 4*($urandom % NS)), {1'($urandom), 23'd0, 8'($urandom % 8)});
        5: wr(16'(16'h2000 + 32*($urandom % NS)), ($urandom % 4 == 0) ? 32'd0 : 32'd1 << ($urandom % 6));
        6: begin @(negedge clk); local_req = 24'($urandom); @(posedge clk); #1; end
        default: rd(($urandom % 2) ? 16'(16'h1000 + 4*($urandom % NS)) : 16'(16'h2000 + 32*($urandom % NS)), "R7 R8 random read");
      endcase
      chk_irq("R3 random");
      if (n % 50 == 0) begin
        rd(16'h0000, "R2 random");
        rd(16'h0104, "R4 random");
      end
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule